// File: doc/BRIEF.md
# Residue-to-Binary Converter (CRT, Eight Moduli)

This block turns a word of eight residue digits back into an ordinary signed two's-complement number. The digits belong to the pairwise-coprime moduli 25, 29, 31, 37, 43, 47, 59 and 64. Their product M = 6,345,994,971,200 gives a little under 43 bits of range. The block is meant for the output end of a datapath that computes in residue form, for example a bank of parallel modular filter channels. Its output feeds logic that expects plain binary.

Each digit selects an entry from a small table built for its own modulus. An entry holds the digit times its CRT weight, already reduced modulo M. The eight entries are compressed with carry-save adders and the result is registered. The next stage does a single carry-propagate add and subtracts the largest multiple of M (up to 7M) that does not exceed the total. The remainder is then folded into the symmetric signed range. M is a multiple of 64, so the six low result bits are taken straight from the digit of modulus 64. The tables are computed at elaboration by constant functions. The converter accepts a new word on every cycle and has a fixed latency of two clock cycles.

Top module: `rns_crt_decoder`

## Requirements
- R1: `out_valid` equals the value `in_valid` had two rising clock edges earlier, so one conversion can be started on every cycle.
- R2: Field k of `res_i` is bits [6k+5:6k]. Fields 0..7 belong to the moduli 25, 29, 31, 37, 43, 47, 59 and 64 in that order. When every digit is below its modulus, `out_value` is congruent to digit k modulo modulus k for all k.
- R3: When `out_valid` is high, `out_value` lies in [-M/2, M/2-1] with M/2 = 3,172,997,485,600.
- R4: A reconstructed value X in [0, M/2-1] is output as X itself. A value in [M/2, M-1] is output as X-M. Hence 0, -1, M/2-1 and -M/2 all come out exactly.
- R5: Bits [5:0] of `out_value` equal the modulus-64 digit (field 7) that was presented two edges earlier.
- R6: A digit that is equal to or above its own modulus counts as zero. The output is the same as for that word with the digit replaced by 0.
- R7: While `rst_n` is low, `out_valid` and `out_value` are both zero.
- R8: Words presented on consecutive cycles are converted independently, and each result appears in input order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Marks `res_i` as a word to convert |
| res_i | input | 48 | Eight 6-bit residue digits, field k at [6k+5:6k] |
| out_valid | output | 1 | Result valid, two cycles after `in_valid` |
| out_value | output | 44 | Signed two's-complement result |

## Verification
The bound checker checks the following on every cycle:
- the two-cycle valid pipeline;
- that each in-range digit is congruent with the result;
- that the result stays inside the signed range;
- that the low six bits equal the modulus-64 digit.

These checks cannot show that the value is the one correct integer out of all congruent candidates, or that over-range digits are dropped correctly. The bench scenarios cover those cases. They include the boundary values 0, -1, M/2-1 and -M/2, words containing out-of-range digits, and back-to-back random streams with gaps. Each result is compared against a reconstruction that the bench builds digit by digit.

// File: rtl/rns_crt_decoder.sv
module rns_crt_decoder #(
  parameter int DW = 6,
  parameter int OW = 44
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [8*DW-1:0]      res_i,
  output logic                 out_valid,
  output logic signed [OW-1:0] out_value
);
  localparam int NM = 8;
  localparam longint unsigned MODV [NM] = '{64'd25, 64'd29, 64'd31, 64'd37,
                                            64'd43, 64'd47, 64'd59, 64'd64};

  function automatic longint unsigned prod_all();
    longint unsigned p;
    p = 1;
    for (int k = 0; k < NM; k++) p = p * MODV[k];
    return p;
  endfunction

  localparam longint unsigned MTOT = prod_all();
  localparam longint unsigned HALF = MTOT / 2;
  localparam int RW = $clog2(MTOT);
  localparam int SW = $clog2(MTOT * NM);

  function automatic longint unsigned crt_term(int k, int x);
    longint unsigned mk, mh, r, a;
    mk = MODV[k];
    mh = MTOT / mk;
    r  = mh % mk;
    a  = 0;
    for (longint unsigned j = 1; j < mk; j++)
      if ((r * j) % mk == 1) a = j;
    return ((a * longint'(x)) % mk) * mh;
  endfunction

  logic [SW-1:0] term [NM];

  for (genvar k = 0; k < NM; k++) begin : g_lut
    logic [RW-1:0] tbl [1<<DW];
    for (genvar x = 0; x < (1 << DW); x++) begin : g_e
      if (longint'(x) < MODV[k]) begin : g_v
        assign tbl[x] = RW'(crt_term(k, x));
      end else begin : g_z
        assign tbl[x] = '0;
      end
    end
    assign term[k] = SW'(tbl[res_i[k*DW +: DW]]);
  end

  logic [SW-1:0] cs_s [NM-1];
  logic [SW-1:0] cs_c [NM-1];
  assign cs_s[0] = term[0];
  assign cs_c[0] = term[1];

  for (genvar k = 1; k < NM - 1; k++) begin : g_csa
    logic [SW-1:0] maj;
    assign cs_s[k] = cs_s[k-1] ^ cs_c[k-1] ^ term[k+1];
    assign maj     = (cs_s[k-1] & cs_c[k-1]) | (cs_s[k-1] & term[k+1]) |
                     (cs_c[k-1] & term[k+1]);
    assign cs_c[k] = {maj[SW-2:0], 1'b0};
  end

  logic [SW-1:0] s1_sum, s1_car;
  logic [DW-1:0] s1_low;
  logic          s1_v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_sum <= '0;
      s1_car <= '0;
      s1_low <= '0;
      s1_v   <= 1'b0;
    end else begin
      s1_sum <= cs_s[NM-2];
      s1_car <= cs_c[NM-2];
      s1_low <= res_i[(NM-1)*DW +: DW];
      s1_v   <= in_valid;
    end
  end

  logic [SW-1:0] tot, rem, sgn;
  assign tot = s1_sum + s1_car;

  always_comb begin
    rem = tot;
    for (int k = 1; k < NM; k++)
      if (tot >= SW'(longint'(k) * MTOT)) rem = tot - SW'(longint'(k) * MTOT);
  end

  assign sgn = (rem >= SW'(HALF)) ? rem - SW'(MTOT) : rem;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_value <= '0;
    end else begin
      out_valid <= s1_v;
      out_value <= {sgn[OW-1:DW], s1_low};
    end
  end
endmodule

// File: rtl/rns_crt_decoder_chk.sv
module rns_crt_decoder_chk #(
  parameter int DW = 6,
  parameter int OW = 44
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_valid,
  input logic [8*DW-1:0]      res_i,
  input logic                 out_valid,
  input logic signed [OW-1:0] out_value
);
  localparam longint MODC [8] = '{64'd25, 64'd29, 64'd31, 64'd37,
                                  64'd43, 64'd47, 64'd59, 64'd64};
  localparam longint MC = 64'd6345994971200;

  logic [1:0]       age;
  logic             v1, v2;
  logic [8*DW-1:0]  d1, d2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      age <= '0; v1 <= 1'b0; v2 <= 1'b0; d1 <= '0; d2 <= '0;
    end else begin
      if (age != 2'd3) age <= age + 2'd1;
      v1 <= in_valid; v2 <= v1; d1 <= res_i; d2 <= d1;
    end
  end

  function automatic longint smod(logic signed [OW-1:0] v, longint m);
    longint s;
    s = longint'(v);
    return ((s % m) + m) % m;
  endfunction

  // R1
  p_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd2) |-> (out_valid == v2));

  // R3
  p_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (longint'(out_value) >= -(MC / 2) && longint'(out_value) < MC / 2));

  // R5
  p_lowbits_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd2 && out_valid) |-> (out_value[DW-1:0] == d2[7*DW +: DW]));

  for (genvar k = 0; k < 8; k++) begin : g_res
    // R2
    p_residue_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (age >= 2'd2 && out_valid && longint'(d2[k*DW +: DW]) < MODC[k])
      |-> (smod(out_value, MODC[k]) == longint'(d2[k*DW +: DW])));
  end
endmodule

bind rns_crt_decoder rns_crt_decoder_chk #(.DW(DW), .OW(OW)) u_chk (.*);

// File: tb/tb_rns_crt_decoder.sv
`timescale 1ns/1ps
module tb_rns_crt_decoder;
  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               in_valid = 1'b0;
  logic [47:0]        res_i = '0;
  logic               out_valid;
  logic signed [43:0] out_value;

  rns_crt_decoder dut (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .res_i(res_i),
                       .out_valid(out_valid), .out_value(out_value));

  always #2.5 clk = ~clk;

  longint MODB [8] = '{25, 29, 31, 37, 43, 47, 59, 64};
  longint MB = 64'd6345994971200;
  int checks = 0, failures = 0;
  bit done = 0;

  logic   hv [2] = '{0, 0};
  longint hx [2] = '{0, 0};
  string  ht [2] = '{"R1", "R1"};

  task automatic check(bit ok, string tag, longint act, longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [47:0] enc(longint x);
    logic [47:0] d;
    for (int k = 0; k < 8; k++) d[k*6 +: 6] = 6'(((x % MODB[k]) + MODB[k]) % MODB[k]);
    return d;
  endfunction

  // independent digit-by-digit reconstruction; over-range digit taken as 0 (R6)
  function automatic longint ref_decode(logic [47:0] d);
    longint x, p, dk;
    x = 0; p = 1;
    for (int k = 0; k < 8; k++) begin
      dk = longint'(d[k*6 +: 6]);
      if (dk >= MODB[k]) dk = 0;
      while ((x % MODB[k]) != dk) x += p;
      p *= MODB[k];
    end
    if (x >= MB / 2) x -= MB;
    return x;
  endfunction

  task automatic step(logic v, logic [47:0] d, string tag);
    @(negedge clk);
    check(out_valid == hv[1], "R1", longint'(out_valid), longint'(hv[1]));
    if (hv[1]) begin
      check(longint'(out_value) == hx[1], ht[1], longint'(out_value), hx[1]);
      check(longint'(out_value) >= -(MB / 2) && longint'(out_value) < MB / 2, "R3",
            longint'(out_value), hx[1]);
      check(out_value[5:0] == 6'(((hx[1] % 64) + 64) % 64), "R5",
            longint'(out_value[5:0]), ((hx[1] % 64) + 64) % 64);
    end
    hv[1] = hv[0]; hx[1] = hx[0]; ht[1] = ht[0];
    hv[0] = v; hx[0] = ref_decode(d); ht[0] = tag;
    in_valid = v; res_i = d;
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [47:0] d;
    longint x;
    in_valid = 1'b1; res_i = enc(12345);
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(out_valid == 1'b0, "R7", longint'(out_valid), 0);
    check(out_value == '0, "R7", longint'(out_value), 0);
    in_valid = 1'b0;
    rst_n = 1'b1;

    // R4 boundaries
    step(1, enc(0), "R4");
    step(1, enc(-1), "R4");
    step(1, enc(MB / 2 - 1), "R4");
    step(1, enc(-(MB / 2)), "R4");
    step(1, enc(1), "R4");
    step(1, enc(MB / 2 - 64), "R4");
    step(0, enc(7), "R1");
    step(1, enc(-123456789), "R2");
    step(1, enc(63), "R2");
    step(1, enc(64), "R2");

    // R6 over-range digits
    d = enc(987654321); d[0 +: 6] = 6'd30;
    step(1, d, "R6");
    d = enc(-55555); d[18 +: 6] = 6'd37; d[36 +: 6] = 6'd63;
    step(1, d, "R6");
    d = '1; d[42 +: 6] = 6'd5;
    step(1, d, "R6");
    step(0, '0, "R1");

    // R8 random back-to-back streams with gaps
    for (int i = 0; i < 400; i++) begin
      x = longint'({$urandom(), $urandom()} & 64'h7FF_FFFF_FFFF) % MB - MB / 2;
      step(($urandom() % 5) != 0, enc(x), "R8");
    end
    for (int i = 0; i < 40; i++) begin
      d = {$urandom(), $urandom()};
      step(1, d, "R6");
    end
    step(0, '0, "R1");
    step(0, '0, "R1");
    step(0, '0, "R1");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule